// File: doc/BRIEF.md
# Memory-Mapped GPIO Controller with Line Interrupts

This block controls up to 32 general-purpose I/O lines through a small word-addressed register bus. For each line, software picks whether the pin is owned by this controller or handed over to an alternate-function port. For pins it owns, software sets the direction, the output enable and the output value. Pin levels pass through a synchroniser. Software can read them back as the input value.

Each line can also raise an interrupt. A line can detect a level (active high or active low) or an edge (rising, falling or both). Detected events latch into a status register, whether or not the line is masked. A read of that register returns the latched bits and clears them, because there is no acknowledge register. The mask register can only be read. Software changes it through two write-one registers, one that unmasks lines and one that masks them. A single interrupt output is high while any latched line is unmasked.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Registers sit at word index = byte offset / 4: 0x00 bypass, 0x04 direction, 0x08 output enable, 0x0C output value, 0x10 input value, 0x14 mask, 0x18 unmask (write-one), 0x1C mask-set (write-one), 0x20 status, 0x24 detect type, 0x28 polarity, 0x2C both-edges. Line i uses bit i of each. After reset, direction and mask read all ones on the implemented lines, and every other register reads 0. The irq output is 0 after reset.
- R2: Read data appears on `bus_rdata` in the cycle after `bus_rd` is sampled. The following read as zero: bits above the line count, the two write-one registers, and unmapped indices.
- R3: With bypass bit 0, a line drives `pin_out` from its output value bit. `pin_oe` is high only when the direction bit is 0 (output) and the output-enable bit is 1. With direction 1 (input), `pin_oe` stays low whatever the output-enable bit holds.
- R4: With bypass bit 1, `pin_out` and `pin_oe` of that line follow `alt_out` and `alt_oe`.
- R5: The input value register returns `pin_in` after a two-flop synchroniser. The output value register returns the stored bits, not the pin levels.
- R6: A 1 written to the unmask register clears that mask bit. A 1 written to the mask-set register sets it. Zero bits change nothing. Writes to the mask register itself are ignored.
- R7: A detect-type bit of 1 selects level detection. A polarity bit of 1 then means active high, and 0 means active low.
- R8: A detect-type bit of 0 selects edge detection. A polarity bit of 1 means rising and 0 means falling. A both-edges bit of 1 makes the line detect either edge.
- R9: A status read returns the latched bits and clears all of them. An event detected in the same cycle as the read stays latched, so a level condition that still holds reads back as set.
- R10: Status latches even for masked lines. `irq` is high exactly when some status bit is set and its mask bit is 0. A pin change reaches `irq` at the third rising clock edge after it.
- R11: Writes to the input value register and to the status register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Word index of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | N_LINES | Pad input levels |
| pin_out | output | N_LINES | Pad output values |
| pin_oe | output | N_LINES | Pad output enables |
| alt_out | input | N_LINES | Alternate-function output values |
| alt_oe | input | N_LINES | Alternate-function output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with 12 lines and the default two-stage synchroniser. With 12 lines, bits 12 to 31 of every register are unimplemented, so the zero padding of read data can be observed. Random sweeps cover pin ownership, direction and output settings. Random interrupt rounds pick a type, polarity, both-edges setting and mask for each line. In each round, every line makes one input transition. The expected status is built from the levels before and after that transition, including level bits that are set again during the clearing read. Directed cases measure the exact latency from a pin change to `irq`, confirm that masked lines still latch status, and check that the unmask and mask-set writes leave zero bits untouched.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   localparam int unsigned BUS_W       = 32;
   localparam int unsigned WORD_ADDR_W = 4;
   localparam int unsigned MAX_LINES   = BUS_W;

   typedef enum logic [WORD_ADDR_W-1:0] {
      SEL_BYPASS = 4'd0,
      SEL_DIR    = 4'd1,
      SEL_OE     = 4'd2,
      SEL_OUT    = 4'd3,
      SEL_IN     = 4'd4,
      SEL_MASK   = 4'd5,
      SEL_UNMASK = 4'd6,
      SEL_MASKSET= 4'd7,
      SEL_STATUS = 4'd8,
      SEL_TYPE   = 4'd9,
      SEL_POL    = 4'd10,
      SEL_BOTH   = 4'd11
   } reg_sel_e;

   // One line's detection decision from its configuration and two samples.
   function automatic logic line_event(input logic is_level, input logic pol,
                                       input logic both, input logic cur,
                                       input logic prev);
      logic rise, fall;
      rise = cur & ~prev;
      fall = ~cur & prev;
      if (is_level)  return (cur == pol);
      else if (both) return rise | fall;
      else           return pol ? rise : fall;
   endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   initial begin
      assert (STAGES >= 2 && STAGES <= 4)
         else $error("gpio_sync: STAGES must be 2..4");
   end

   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
   import gpio_irq_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cur,
   input  logic [W-1:0] lvl_sel,
   input  logic [W-1:0] pol,
   input  logic [W-1:0] both,
   output logic [W-1:0] evt
);

   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= cur;
   end

   for (genvar i = 0; i < W; i++) begin : g_line
      assign evt[i] = line_event(lvl_sel[i], pol[i], both[i], cur[i], prev_q[i]);
   end

   // R8: an edge-mode event needs the sampled level to have moved
   a_r8_edge_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt & ~lvl_sel & ~(cur ^ prev_q)) == '0));

   // R7: a level-mode event only while the level equals the polarity
   a_r7_level_matches_pol: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt & lvl_sel & (cur ^ pol)) == '0));

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] bypass,
   input  logic [W-1:0] dir_in,
   input  logic [W-1:0] oe,
   input  logic [W-1:0] out,
   input  logic [W-1:0] alt_out,
   input  logic [W-1:0] alt_oe,
   output logic [W-1:0] pin_out,
   output logic [W-1:0] pin_oe
);

   for (genvar i = 0; i < W; i++) begin : g_pad
      always_comb begin
         if (bypass[i]) begin
            pin_out[i] = alt_out[i];
            pin_oe[i]  = alt_oe[i];
         end else begin
            pin_out[i] = out[i];
            pin_oe[i]  = oe[i] & ~dir_in[i];
         end
      end
   end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
   import gpio_irq_pkg::*;
#(
   parameter int unsigned N_LINES     = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [WORD_ADDR_W-1:0] bus_addr,
   input  logic                   bus_wr,
   input  logic [BUS_W-1:0]       bus_wdata,
   input  logic                   bus_rd,
   output logic [BUS_W-1:0]       bus_rdata,
   input  logic [N_LINES-1:0]     pin_in,
   output logic [N_LINES-1:0]     pin_out,
   output logic [N_LINES-1:0]     pin_oe,
   input  logic [N_LINES-1:0]     alt_out,
   input  logic [N_LINES-1:0]     alt_oe,
   output logic                   irq
);

   localparam logic [N_LINES-1:0] ALL_LINES = '1;

   initial begin
      assert (N_LINES >= 1 && N_LINES <= MAX_LINES)
         else $error("gpio_irq_ctrl: N_LINES must be 1..32");
   end

   reg_sel_e           sel;
   logic [N_LINES-1:0] wdata_l;
   logic [N_LINES-1:0] bypass_q, dir_q, oe_q, out_q;
   logic [N_LINES-1:0] mask_q, type_q, pol_q, both_q, status_q;
   logic [N_LINES-1:0] sync_in, evt;
   logic [N_LINES-1:0] rd_line;
   logic [BUS_W-1:0]   rd_word;
   logic               stat_rd;

   assign sel     = reg_sel_e'(bus_addr);
   assign wdata_l = bus_wdata[N_LINES-1:0];
   assign stat_rd = bus_rd && (sel == SEL_STATUS);

   gpio_sync #(.W(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk), .rst_n (rst_n), .d (pin_in), .q (sync_in)
   );

   gpio_evt_detect #(.W(N_LINES)) u_detect (
      .clk (clk), .rst_n (rst_n), .cur (sync_in),
      .lvl_sel (type_q), .pol (pol_q), .both (both_q), .evt (evt)
   );

   gpio_pad_mux #(.W(N_LINES)) u_pads (
      .bypass (bypass_q), .dir_in (dir_q), .oe (oe_q), .out (out_q),
      .alt_out (alt_out), .alt_oe (alt_oe),
      .pin_out (pin_out), .pin_oe (pin_oe)
   );

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bypass_q <= '0;
         dir_q    <= ALL_LINES;
         oe_q     <= '0;
         out_q    <= '0;
         type_q   <= '0;
         pol_q    <= '0;
         both_q   <= '0;
      end else if (bus_wr) begin
         case (sel)
            SEL_BYPASS: bypass_q <= wdata_l;
            SEL_DIR:    dir_q    <= wdata_l;
            SEL_OE:     oe_q     <= wdata_l;
            SEL_OUT:    out_q    <= wdata_l;
            SEL_TYPE:   type_q   <= wdata_l;
            SEL_POL:    pol_q    <= wdata_l;
            SEL_BOTH:   both_q   <= wdata_l;
            default: ;
         endcase
      end
   end

   // mask: only the write-one registers move it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= ALL_LINES;
      end else if (bus_wr && sel == SEL_UNMASK) begin
         mask_q <= mask_q & ~wdata_l;
      end else if (bus_wr && sel == SEL_MASKSET) begin
         mask_q <= mask_q | wdata_l;
      end
   end

   // status: clear on read, same-cycle events survive
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= (stat_rd ? '0 : status_q) | evt;
   end

   always_comb begin
      case (sel)
         SEL_BYPASS: rd_line = bypass_q;
         SEL_DIR:    rd_line = dir_q;
         SEL_OE:     rd_line = oe_q;
         SEL_OUT:    rd_line = out_q;
         SEL_IN:     rd_line = sync_in;
         SEL_MASK:   rd_line = mask_q;
         SEL_STATUS: rd_line = status_q;
         SEL_TYPE:   rd_line = type_q;
         SEL_POL:    rd_line = pol_q;
         SEL_BOTH:   rd_line = both_q;
         default:    rd_line = '0;
      endcase
      rd_word = '0;
      rd_word[N_LINES-1:0] = rd_line;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_word;
   end

   assign irq = |(status_q & ~mask_q);

   // R6: unmask write clears every written-one mask bit
   a_r6_unmask_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel == SEL_UNMASK) |=> ((mask_q & $past(wdata_l)) == '0));

   // R6: mask-set write sets every written-one mask bit
   a_r6_maskset_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel == SEL_MASKSET) |=> ((mask_q & $past(wdata_l)) == $past(wdata_l)));

   // R6: no other access touches the mask
   a_r6_mask_held: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && (sel == SEL_UNMASK || sel == SEL_MASKSET)) |=> $stable(mask_q));

   // R9: after a status read only fresh events remain
   a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd |=> ((status_q & ~$past(evt)) == '0));

   // R3: an owned input line is never driven
   a_r3_input_not_driven: assert property (@(posedge clk) disable iff (!rst_n)
      ((~bypass_q & dir_q & pin_oe) == '0));

   // R2: write-one registers read as zero
   a_r2_wo_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && (sel == SEL_UNMASK || sel == SEL_MASKSET)) |=> (bus_rdata == '0));

endmodule

// File: tb/gpio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_bench;

   localparam int N = 12;
   localparam logic [N-1:0] ALL = '1;
   localparam logic [3:0] A_BYP = 4'd0, A_DIR = 4'd1, A_OE = 4'd2, A_OUT = 4'd3,
                          A_IN = 4'd4, A_MASK = 4'd5, A_UNM = 4'd6, A_MSET = 4'd7,
                          A_STAT = 4'd8, A_TYPE = 4'd9, A_POL = 4'd10, A_BOTH = 4'd11;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [N-1:0] pin_in = '0, pin_out, pin_oe, alt_out = '0, alt_oe = '0;
   logic irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [N-1:0] m_byp, m_dir, m_oe, m_out, m_mask, m_typ, m_pol, m_any;

   always #2.5 clk = ~clk;

   gpio_irq_ctrl #(.N_LINES(N), .SYNC_STAGES(2)) u_gpio_irq_ctrl (
      .clk, .rst_n, .bus_addr, .bus_wr, .bus_wdata, .bus_rd, .bus_rdata,
      .pin_in, .pin_out, .pin_oe, .alt_out, .alt_oe, .irq
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [N-1:0] exp_oe();
      return (m_byp & alt_oe) | (~m_byp & ~m_dir & m_oe);
   endfunction

   function automatic logic [N-1:0] exp_po();
      return (m_byp & alt_out) | (~m_byp & m_out);
   endfunction

   // expected status after one transition old->nw, including the clearing read at old
   function automatic logic [N-1:0] exp_stat(input logic [N-1:0] old, input logic [N-1:0] nw);
      logic [N-1:0] r;
      for (int i = 0; i < N; i++) begin
         if (m_typ[i])      r[i] = m_pol[i] ? (old[i] | nw[i]) : (~old[i] | ~nw[i]);
         else if (m_any[i]) r[i] = old[i] ^ nw[i];
         else if (m_pol[i]) r[i] = ~old[i] & nw[i];
         else               r[i] = old[i] & ~nw[i];
      end
      return r;
   endfunction

   function automatic logic [31:0] z(input logic [N-1:0] v);
      logic [31:0] w;
      w = '0;
      w[N-1:0] = v;
      return w;
   endfunction

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic [N-1:0] old, nw, v, e;
      void'($urandom(32'd1234));

      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset values
      rd(A_BYP, d);  chk("R1 bypass reset", d, 0);
      rd(A_DIR, d);  chk("R1 dir reset", d, z(ALL));
      rd(A_OE, d);   chk("R1 oe reset", d, 0);
      rd(A_OUT, d);  chk("R1 out reset", d, 0);
      rd(A_MASK, d); chk("R1 mask reset", d, z(ALL));
      rd(A_TYPE, d); chk("R1 type reset", d, 0);
      rd(A_STAT, d); chk("R1 status reset", d, 0);
      chk("R1 irq reset", irq, 0);
      chk("R3 no drive at reset", pin_oe, 0);

      // R2 zero reads
      wr(A_BYP, 32'hFFFF_FFFF);
      rd(A_BYP, d);  chk("R2 upper bits zero", d, z(ALL));
      wr(A_BYP, 0);
      rd(A_UNM, d);  chk("R2 unmask reads zero", d, 0);
      rd(A_MSET, d); chk("R2 maskset reads zero", d, 0);
      rd(4'd13, d);  chk("R2 unmapped reads zero", d, 0);

      // R3/R4/R5 random pad control
      for (int k = 0; k < 30; k++) begin
         m_byp = N'($urandom); m_dir = N'($urandom);
         m_oe = N'($urandom);  m_out = N'($urandom);
         wr(A_BYP, z(m_byp)); wr(A_DIR, z(m_dir));
         wr(A_OE, z(m_oe));   wr(A_OUT, z(m_out));
         @(negedge clk);
         alt_out = N'($urandom); alt_oe = N'($urandom);
         #1;
         chk("R3 R4 pin_oe", pin_oe, exp_oe());
         chk("R3 R4 pin_out", pin_out, exp_po());
         rd(A_OUT, d);  chk("R5 out reg stored bits", d, z(m_out));
         rd(A_DIR, d);  chk("R1 dir readback", d, z(m_dir));
      end
      m_dir = ALL; m_oe = ALL; m_byp = '0;
      wr(A_DIR, z(m_dir)); wr(A_OE, z(m_oe)); wr(A_BYP, 0);
      #1 chk("R3 oe ignored for inputs", pin_oe, 0);

      // R5 input value, R11 ignored writes
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         v = N'($urandom);
         pin_in = v;
         idle(3);
         rd(A_IN, d); chk("R5 input value", d, z(v));
         wr(A_IN, z(~v));
         rd(A_IN, d); chk("R11 input write ignored", d, z(v));
      end
      pin_in = '0;
      idle(4);
      rd(A_STAT, d);
      wr(A_STAT, 32'hFFFF_FFFF);
      rd(A_STAT, d); chk("R11 status write ignored", d, 0);

      // R6 mask access
      m_mask = ALL;
      wr(A_UNM, 32'h5);   m_mask &= ~N'(5);
      rd(A_MASK, d); chk("R6 unmask zeros ignored", d, z(m_mask));
      wr(A_MSET, 32'h1);  m_mask |= N'(1);
      rd(A_MASK, d); chk("R6 maskset zeros ignored", d, z(m_mask));
      wr(A_MASK, 0);
      rd(A_MASK, d); chk("R6 mask write ignored", d, z(m_mask));
      wr(A_MSET, 32'hFFFF_FFFF); m_mask = ALL;

      // R10 masked line latches; latency
      m_typ = '0; m_pol = ALL; m_any = '0;
      wr(A_TYPE, 0); wr(A_POL, z(ALL)); wr(A_BOTH, 0);
      rd(A_STAT, d);
      pin_in = 12'h002;
      idle(4);
      chk("R10 masked line no irq", irq, 0);
      rd(A_STAT, d); chk("R10 masked status latched", d, 32'h2);
      wr(A_UNM, 32'h1); m_mask = ALL & ~N'(1);
      rd(A_STAT, d);
      pin_in = 12'h003;
      repeat (2) @(posedge clk);
      @(negedge clk); chk("R10 irq not before third edge", irq, 0);
      @(posedge clk);
      @(negedge clk); chk("R10 irq at third edge", irq, 1);
      rd(A_STAT, d); chk("R8 rising latched", d, 32'h1);
      chk("R9 irq cleared by read", irq, 0);

      // R7/R9 level persists through read
      wr(A_TYPE, 32'h1);
      idle(2);
      rd(A_STAT, d); chk("R7 level high status", d, 32'h1);
      rd(A_STAT, d); chk("R9 held level re-sets", d, 32'h1);
      pin_in = 12'h002;
      idle(4);
      rd(A_STAT, d); chk("R9 latched after level gone", d, 32'h1);
      rd(A_STAT, d); chk("R9 cleared after level gone", d, 0);

      // R7/R8/R9/R10 random rounds
      for (int k = 0; k < 24; k++) begin
         m_typ = N'($urandom); m_pol = N'($urandom);
         m_any = N'($urandom); m_mask = N'($urandom);
         wr(A_TYPE, z(m_typ)); wr(A_POL, z(m_pol)); wr(A_BOTH, z(m_any));
         wr(A_MSET, z(m_mask)); wr(A_UNM, z(~m_mask));
         old = N'($urandom); nw = N'($urandom);
         @(negedge clk); pin_in = old;
         idle(4);
         rd(A_STAT, d);
         pin_in = nw;
         idle(4);
         e = exp_stat(old, nw);
         chk("R10 irq from unmasked status", irq, |(e & ~m_mask));
         rd(A_STAT, d); chk("R7 R8 status", d, z(e));
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule